// File: doc/BRIEF.md
# Prefix-Length Region Pointer Allocator

This block keeps the address bookkeeping for a priority-ordered match table. The table is split into one region per prefix length. The region for the longest prefix sits at the lowest addresses, and each shorter prefix follows in turn. For every region the block holds two pointers: the base where the region begins, and the fill pointer where the next entry will go. A region ends where the following region begins. The last region ends at the top of the table.

Table-management logic sends one command per cycle and gets one response in the next cycle. There are three commands:

- An insert names a region. It returns the address where the new entry should be written, or a full flag.
- A remove-last command takes back the most recently placed entry of a region.
- A boundary command moves the base of a region. The caller issues it once the entries have been relocated.

The block never touches the table contents. It only hands out addresses and updates its pointers.

Top module: `prefix_region_alloc`

## Requirements
- R1: After reset, region r (0..30) has base r*2 and is empty (fill pointer equals base). The table holds 64 addresses, so region 30 covers 60..63 and ends at address 64.
- R2: The command opcode 2'b00 means insert. An insert into a region that is not full returns that region's fill pointer on rsp_addr, with rsp_full=0 and rsp_err=0. The same cycle's update raises the fill pointer by one, so back-to-back inserts return consecutive addresses.
- R3: The end of a region is the base of the next region, or 64 for the last one. An insert into a region whose fill pointer equals its end returns rsp_full=1 and rsp_addr=0, and leaves every pointer unchanged.
- R4: The opcode 2'b01 means remove-last. It lowers the region's fill pointer by one. On an empty region it returns rsp_err=1 and changes nothing, so the fill pointer never drops below the base.
- R5: The opcode 2'b10 means set-boundary. It moves the base of region cmd_region to cmd_value. This changes where the previous region ends, and the next insert into the previous region sees the new limit. The fill pointers are left as they are.
- R6: A set-boundary is rejected with rsp_err=1, and changes nothing, in three cases: it targets region 0; cmd_value is above that region's own fill pointer; or cmd_value is below the previous region's fill pointer.
- R7: A region index of 31, or the reserved opcode 2'b11, returns rsp_err=1 and changes nothing.
- R8: rsp_valid is high exactly in the cycle after each accepted command. rsp_full and rsp_err are never high together. rsp_addr is 0 on every response other than a successful insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 00 insert, 01 remove-last, 10 set-boundary, 11 reserved |
| cmd_region | input | 5 | Region index (0 = longest prefix) |
| cmd_value | input | 7 | New base address for set-boundary |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_full | output | 1 | Insert refused: region full |
| rsp_err | output | 1 | Command rejected |
| rsp_addr | output | 6 | Address at which to write the inserted entry |

## Verification
Several properties are checked on every cycle:
- every fill pointer stays between its region's base and end;
- bases stay in ascending order, with region 0 fixed at address 0;
- a successful insert returns the old fill pointer and raises it by one;
- full and rejected responses leave all pointers untouched;
- the response flags stay mutually exclusive.

Some behaviour can only be shown by the bench's command sequences. Examples are the exact reset layout, the capacity of the last region up to the table top, and how a moved boundary changes what later inserts into both neighbouring regions return. The same holds for the exact conditions under which a boundary move is refused.

// File: rtl/prefix_region_alloc.sv
module prefix_region_alloc #(
  parameter int NREG  = 31,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int RW   = $clog2(NREG + 1),
  localparam int STEP = DEPTH / NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_region,
  input  logic [PW-1:0] cmd_value,
  output logic          rsp_valid,
  output logic          rsp_full,
  output logic          rsp_err,
  output logic [AW-1:0] rsp_addr
);
  localparam logic [1:0] OP_INS = 2'b00, OP_DEL = 2'b01, OP_BND = 2'b10;

  logic [NREG-1:0][PW-1:0] start_q, free_q, end_w, prevf_w;

  for (genvar r = 0; r < NREG; r++) begin : g_nb
    if (r == NREG - 1) begin : g_last
      assign end_w[r] = PW'(DEPTH);
    end else begin : g_mid
      assign end_w[r] = start_q[r+1];
    end
    if (r == 0) begin : g_first
      assign prevf_w[r] = '0;
    end else begin : g_rest
      assign prevf_w[r] = free_q[r-1];
    end
  end

  wire          in_range = {1'b0, cmd_region} < (RW+1)'(NREG);
  wire [RW-1:0] idx      = in_range ? cmd_region : '0;
  wire [PW-1:0] s_base   = start_q[idx];
  wire [PW-1:0] s_free   = free_q[idx];
  wire [PW-1:0] s_end    = end_w[idx];
  wire [PW-1:0] s_prevf  = prevf_w[idx];

  wire ins_ok  = in_range && cmd_op == OP_INS && s_free != s_end;
  wire ins_ful = in_range && cmd_op == OP_INS && s_free == s_end;
  wire del_ok  = in_range && cmd_op == OP_DEL && s_free != s_base;
  wire bnd_ok  = in_range && cmd_op == OP_BND && idx != '0 &&
                 cmd_value <= s_free && cmd_value >= s_prevf;
  wire rej     = !(ins_ok || ins_ful || del_ok || bnd_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        start_q[r] <= PW'(r * STEP);
        free_q[r]  <= PW'(r * STEP);
      end
      rsp_valid <= 1'b0;
      rsp_full  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_full  <= cmd_valid && ins_ful;
      rsp_err   <= cmd_valid && rej;
      rsp_addr  <= (cmd_valid && ins_ok) ? s_free[AW-1:0] : '0;
      if (cmd_valid) begin
        if (ins_ok) free_q[idx]  <= s_free + PW'(1);
        if (del_ok) free_q[idx]  <= s_free - PW'(1);
        if (bnd_ok) start_q[idx] <= cmd_value;
      end
    end
  end
endmodule

// File: rtl/prefix_region_alloc_chk.sv
module prefix_region_alloc_chk #(
  parameter int NREG  = 31,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int RW   = $clog2(NREG + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [1:0]              cmd_op,
  input logic [RW-1:0]           cmd_region,
  input logic                    rsp_valid,
  input logic                    rsp_full,
  input logic                    rsp_err,
  input logic [AW-1:0]           rsp_addr,
  input logic [NREG-1:0][PW-1:0] start_q,
  input logic [NREG-1:0][PW-1:0] free_q
);
  p_base_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_q[0] == '0);

  p_insert_bump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_full && !rsp_err && $past(cmd_op) == 2'b00) |->
      (free_q[$past(cmd_region)] == $past(free_q[cmd_region]) + PW'(1) &&
       {1'b0, rsp_addr} == $past(free_q[cmd_region])));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> (free_q == $past(free_q) && start_q == $past(start_q)));

  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (free_q == $past(free_q) && start_q == $past(start_q)));

  p_rsp_follows_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_full && rsp_err));

  p_addr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_full || rsp_err || !rsp_valid) |-> rsp_addr == '0);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    p_fill_above_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q[r] <= free_q[r]);
    if (r < NREG - 1) begin : g_mid
      p_fill_below_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        free_q[r] <= start_q[r+1]);
    end else begin : g_last
      p_fill_below_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        free_q[r] <= PW'(DEPTH));
    end
  end
endmodule

bind prefix_region_alloc prefix_region_alloc_chk #(.NREG(NREG), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_prefix_region_alloc.sv
module tb_prefix_region_alloc;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [4:0] cmd_region = '0;
  logic [6:0] cmd_value = '0;
  logic       rsp_valid, rsp_full, rsp_err;
  logic [5:0] rsp_addr;

  int checks = 0, errors = 0;
  logic   done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  prefix_region_alloc dut (.*);

  always #5 clk = ~clk;

  localparam logic [1:0] INS = 2'b00, DEL = 2'b01, BND = 2'b10, RSV = 2'b11;

  task automatic issue(input logic [1:0] op, input int region, input int value,
                       input int eaddr, input bit efull, input bit eerr, input string tag);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_region = 5'(region);
    cmd_value  = 7'(value);
    exp_q.push_back({eerr, efull, 6'(eaddr)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: response without command, got err=%0b full=%0b addr=%0d expected none",
                 rsp_err, rsp_full, rsp_addr);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_err, rsp_full, rsp_addr} != e) begin
          errors++;
          $display("FAIL %s: got err=%0b full=%0b addr=%0d expected err=%0b full=%0b addr=%0d",
                   t, rsp_err, rsp_full, rsp_addr, e[7], e[6], e[5:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rsp_valid in reset got %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;

    issue(INS, 0, 0, 0, 0, 0, "R2 first insert r0");
    issue(INS, 0, 0, 1, 0, 0, "R2 second insert r0");
    issue(INS, 0, 0, 0, 1, 0, "R3 region 0 full");
    issue(INS, 30, 0, 60, 0, 0, "R1 last region base");
    issue(INS, 30, 0, 61, 0, 0, "R2 r30");
    issue(INS, 30, 0, 62, 0, 0, "R2 r30");
    issue(INS, 30, 0, 63, 0, 0, "R1 last region top");
    issue(INS, 30, 0, 0, 1, 0, "R3 last region full at 64");
    issue(DEL, 0, 0, 0, 0, 0, "R4 remove-last r0");
    issue(INS, 0, 0, 1, 0, 0, "R4 slot reused");
    issue(DEL, 5, 0, 0, 0, 1, "R4 remove on empty");
    issue(INS, 5, 0, 10, 0, 0, "R4 empty region unchanged");
    issue(BND, 1, 4, 0, 0, 1, "R6 base above own fill");
    issue(INS, 2, 0, 4, 0, 0, "R2 r2");
    issue(INS, 2, 0, 5, 0, 0, "R2 r2");
    issue(BND, 2, 5, 0, 0, 0, "R5 move r2 base to 5");
    issue(INS, 1, 0, 2, 0, 0, "R5 r1");
    issue(INS, 1, 0, 3, 0, 0, "R5 r1");
    issue(INS, 1, 0, 4, 0, 0, "R5 r1 uses gained slot");
    issue(INS, 1, 0, 0, 1, 0, "R5 r1 full at new end 5");
    issue(INS, 2, 0, 0, 1, 0, "R5 r2 full");
    issue(BND, 2, 4, 0, 0, 1, "R6 below previous fill");
    issue(BND, 3, 5, 0, 0, 1, "R6 below previous fill r3");
    issue(BND, 0, 0, 0, 0, 1, "R6 region 0 fixed");
    issue(INS, 31, 0, 0, 0, 1, "R7 region 31");
    issue(RSV, 0, 0, 0, 0, 1, "R7 reserved opcode");
    issue(INS, 0, 0, 0, 1, 0, "R7 no change after reject");
    issue(DEL, 2, 0, 0, 0, 0, "R4 remove r2");
    issue(BND, 3, 5, 0, 0, 0, "R5 move r3 base down");
    issue(INS, 2, 0, 0, 1, 0, "R5 r2 shrunk to full");
    issue(INS, 3, 0, 6, 0, 0, "R5 r3 fill unchanged");
    idle(4);
    checks++;
    if (rsp_valid !== 1'b0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: idle got valid=%b pending=%0d expected 0 0", rsp_valid, exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule